// File: doc/BRIEF.md
# Serial Register-Access Bridge

This block lets a host reach the small register file of a timing-receiver chip over a two-wire I2C bus. The host writes a 16-bit command word that carries a data byte, a 5-bit register number, a direction flag and an abort bit. A 16-bit status word returns the last byte fetched, a busy flag and an error flag.

There is no separate go bit. A command runs whenever the host stores a value that differs from the one already held. While a transfer runs, further command writes are dropped, unless they carry the abort bit. Every access uses two bus frames. The first frame loads the chip's pointer register with the register number. The second frame moves the data byte to or from the chip's data register.

The chip's bus address is its 6-bit base identifier followed by one select bit. SCL and SDA are open-drain, and the block only drives each line low. The bus speed is set by a quarter-bit clock divider.

Top module: `i2c_regbridge`

## Requirements
- R1: After reset the command readback, the status word and both line pull-down enables (`scl_oe`, `sda_oe`) are all zero.
- R2: A host write with bit 15 clear, made while idle, whose bits 14:0 differ from the stored ones, is stored and starts a transfer. Status bit 13 (busy) reads 1 in the first cycle after the write edge, and readback bit 15 always reads 0.
- R3: A host write whose bits 14:0 equal the stored value starts nothing: busy stays 0 and SCL is never pulled low.
- R4: A host write with bit 15 clear, made while busy, is ignored. The readback keeps the running command, and that transfer completes with its own data.
- R5: For a write command (bit 13 = 1, register number in bits 12:8, data in bits 7:0), the bridge sends two frames. The first is address {BASE_ID,0} with R/W=0 and then the register number. The second is address {BASE_ID,1} with R/W=0 and then the data byte. Each frame ends with STOP.
- R6: For a read command (bit 13 = 0), the first frame is the same as in R5. The second frame is address {BASE_ID,1} with R/W=1, then one byte received MSB first, then NACK and STOP. The received byte appears in status bits 7:0.
- R7: If any byte except the received one is not acknowledged, status bit 14 (error) is set. The bridge then sends STOP at once, with no further frame, and busy clears. Both lines end released.
- R8: The error bit clears in the cycle a new transfer starts.
- R9: A host write with bit 15 set clears busy, error, the read byte and the stored command. It releases both lines in the next cycle, and no further bus activity follows.
- R10: A command whose register number is NUM_REGS (20) or more ends with the error bit set within two cycles of the write edge, and SCL is never pulled low.
- R11: Every SCL high time inside a frame lasts exactly 2*QUARTER_CYC clock cycles. A full access produces 38 SCL falling edges: one per START plus 18 per frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Host write strobe for the command word |
| ctrl_wdata | input | 16 | Command word: [7:0] data, [12:8] register, [13] write, [14] spare, [15] abort |
| ctrl_q | output | 16 | Command readback (bit 15 reads 0) |
| stat_q | output | 16 | Status: [7:0] read byte, [13] busy, [14] error |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | Sensed SDA line level |

## Verification
A host command write can land in the same cycle as an active transfer stepping through its bits. The bench provokes this twice. First, it writes a different command while a write access is mid-frame. The stored command must stay unchanged, and the bus model's target register must receive the original byte. Second, it writes the abort bit about 100 cycles into a frame, with a bus model that may still be holding SDA low. The bridge must release both lines and drop busy in the very next cycle without flagging an error. The target register must be untouched, and no SCL edge may follow.

// File: rtl/i2c_regbridge_pkg.sv
package i2c_regbridge_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHECK,
      ST_START,
      ST_BITS,
      ST_STOP
   } seq_state_t;

   // Packed so that it overlays command bits 13:0 directly
   typedef struct packed {
      logic       wr;
      logic [4:0] regn;
      logic [7:0] wdata;
   } cmd_t;

   localparam int ABORT_BIT = 15;
   localparam int BUSY_BIT  = 13;
   localparam int ERR_BIT   = 14;

endpackage

// File: rtl/i2c_rb_tick.sv
module i2c_rb_tick #(
   parameter int QUARTER_CYC = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (QUARTER_CYC == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(QUARTER_CYC);
         logic [CW-1:0] cnt;
         logic          last;
         assign last = (cnt == CW'(QUARTER_CYC - 1));
         always_ff @(posedge clk) begin
            if (!rst_n)            cnt <= '0;
            else if (!run || last) cnt <= '0;
            else                   cnt <= cnt + 1'b1;
         end
         assign tick = run && last;
      end
   endgenerate
endmodule

// File: rtl/i2c_rb_cmd.sv
module i2c_rb_cmd
   import i2c_regbridge_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we,
   input  logic [15:0] wdata,
   input  logic        busy,
   output logic [14:0] ctrl_r,
   output logic        start,
   output logic        abort,
   output cmd_t        cmd
);
   logic changed;

   assign abort   = we && wdata[ABORT_BIT];
   assign changed = (wdata[14:0] != ctrl_r);
   assign start   = we && !wdata[ABORT_BIT] && !busy && changed;
   assign cmd     = cmd_t'(wdata[13:0]);

   always_ff @(posedge clk) begin
      if (!rst_n)     ctrl_r <= '0;
      else if (abort) ctrl_r <= '0;
      else if (start) ctrl_r <= wdata[14:0];
   end

   // R4: writes during a transfer leave the stored command alone
   assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && we && !wdata[ABORT_BIT]) |=> $stable(ctrl_r));

   // R9: abort wipes the stored command
   assert_abort_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wdata[ABORT_BIT]) |=> (ctrl_r == '0));
endmodule

// File: rtl/i2c_rb_seq.sv
module i2c_rb_seq
   import i2c_regbridge_pkg::*;
#(
   parameter logic [5:0] BASE_ID  = 6'd4,
   parameter int         NUM_REGS = 20
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       abort,
   input  cmd_t       cmd,
   input  logic       tick,
   input  logic       sda_i,
   output logic       busy,
   output logic       err,
   output logic [7:0] rdata,
   output logic       run,
   output logic       scl_oe,
   output logic       sda_oe
);
   seq_state_t state;
   cmd_t       cmd_r;
   logic [1:0] phase;
   logic [3:0] bitn;
   logic       bytn;
   logic       frm;
   logic       nack;
   logic [7:0] shreg;
   logic [7:0] rxsh;
   logic       rd_byte;
   logic [7:0] f0_b0, f0_b1, f1_b0, f1_b1;

   assign rd_byte = frm && bytn && !cmd_r.wr;
   assign f0_b0   = {BASE_ID, 1'b0, 1'b0};
   assign f0_b1   = {3'b000, cmd_r.regn};
   assign f1_b0   = {BASE_ID, 1'b1, !cmd_r.wr};
   assign f1_b1   = cmd_r.wdata;

   assign busy = (state != ST_IDLE);
   assign run  = (state == ST_START) || (state == ST_BITS) || (state == ST_STOP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cmd_r <= '0;
         phase <= '0;
         bitn  <= '0;
         bytn  <= 1'b0;
         frm   <= 1'b0;
         nack  <= 1'b0;
         err   <= 1'b0;
         shreg <= '0;
         rxsh  <= '0;
         rdata <= '0;
      end else if (abort) begin
         state <= ST_IDLE;
         phase <= '0;
         nack  <= 1'b0;
         err   <= 1'b0;
         rdata <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  cmd_r <= cmd;
                  err   <= 1'b0;
                  nack  <= 1'b0;
                  state <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (int'(cmd_r.regn) >= NUM_REGS) begin
                  err   <= 1'b1;
                  state <= ST_IDLE;
               end else begin
                  frm   <= 1'b0;
                  bytn  <= 1'b0;
                  bitn  <= '0;
                  phase <= '0;
                  shreg <= f0_b0;
                  state <= ST_START;
               end
            end
            ST_START: begin
               if (tick) begin
                  phase <= phase + 2'd1;
                  if (phase == 2'd3) begin
                     bitn  <= '0;
                     state <= ST_BITS;
                  end
               end
            end
            ST_BITS: begin
               if (tick) begin
                  phase <= phase + 2'd1;
                  if (phase == 2'd1) begin
                     if (bitn != 4'd8)           rxsh <= {rxsh[6:0], sda_i};
                     else if (!rd_byte && sda_i) nack <= 1'b1;
                  end
                  if (phase == 2'd3) begin
                     if (bitn != 4'd8) begin
                        shreg <= {shreg[6:0], 1'b0};
                        bitn  <= bitn + 4'd1;
                     end else if (nack || bytn) begin
                        if (rd_byte) rdata <= rxsh;
                        state <= ST_STOP;
                     end else begin
                        bytn  <= 1'b1;
                        bitn  <= '0;
                        shreg <= frm ? f1_b1 : f0_b1;
                     end
                  end
               end
            end
            ST_STOP: begin
               if (tick) begin
                  phase <= phase + 2'd1;
                  if (phase == 2'd3) begin
                     if (nack) begin
                        err   <= 1'b1;
                        state <= ST_IDLE;
                     end else if (!frm) begin
                        frm   <= 1'b1;
                        bytn  <= 1'b0;
                        bitn  <= '0;
                        shreg <= f1_b0;
                        state <= ST_START;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      scl_oe = 1'b0;
      sda_oe = 1'b0;
      case (state)
         ST_START: begin
            scl_oe = phase[1];
            sda_oe = (phase != 2'd0);
         end
         ST_BITS: begin
            scl_oe = (phase == 2'd0) || (phase == 2'd3);
            sda_oe = (bitn != 4'd8) && !rd_byte && !shreg[7];
         end
         ST_STOP: begin
            scl_oe = (phase == 2'd0);
            sda_oe = !phase[1];
         end
         default: ;
      endcase
   end

   // R5: data on SDA holds while SCL is high inside a byte
   assert_sda_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BITS && $past(state == ST_BITS) && !scl_oe && !$past(scl_oe))
      |-> $stable(sda_oe));

   // R7: the error flag only rises as the transfer ends
   assert_err_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> !busy);

   // R9: abort frees the bus on the next cycle
   assert_abort_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!busy && !scl_oe && !sda_oe && !err));

   // R10: out-of-range register numbers fail without touching the bus
   assert_range_fail_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CHECK && int'(cmd_r.regn) >= NUM_REGS && !abort) |=> (err && !busy));
endmodule

// File: rtl/i2c_regbridge.sv
module i2c_regbridge
   import i2c_regbridge_pkg::*;
#(
   parameter int         QUARTER_CYC = 100,
   parameter logic [5:0] BASE_ID     = 6'd4,
   parameter int         NUM_REGS    = 20
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ctrl_we,
   input  logic [15:0] ctrl_wdata,
   output logic [15:0] ctrl_q,
   output logic [15:0] stat_q,
   output logic        scl_oe,
   output logic        sda_oe,
   input  logic        sda_i
);
   generate
      if (QUARTER_CYC < 1) begin : g_bad_div
         $error("QUARTER_CYC must be at least 1");
      end
      if (NUM_REGS < 1 || NUM_REGS > 32) begin : g_bad_regs
         $error("NUM_REGS must lie in 1..32");
      end
   endgenerate

   logic [14:0] ctrl_r;
   logic        start, abort, busy, err, run, tick;
   logic [7:0]  rdata;
   cmd_t        cmd;

   i2c_rb_cmd u_cmd (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (ctrl_we),
      .wdata  (ctrl_wdata),
      .busy   (busy),
      .ctrl_r (ctrl_r),
      .start  (start),
      .abort  (abort),
      .cmd    (cmd)
   );

   i2c_rb_tick #(.QUARTER_CYC(QUARTER_CYC)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick)
   );

   i2c_rb_seq #(.BASE_ID(BASE_ID), .NUM_REGS(NUM_REGS)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .abort  (abort),
      .cmd    (cmd),
      .tick   (tick),
      .sda_i  (sda_i),
      .busy   (busy),
      .err    (err),
      .rdata  (rdata),
      .run    (run),
      .scl_oe (scl_oe),
      .sda_oe (sda_oe)
   );

   assign ctrl_q = {1'b0, ctrl_r};
   assign stat_q = {1'b0, err, busy, 5'b00000, rdata};

   // R2: a fresh command raises busy on the next cycle
   assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_q[BUSY_BIT] && ctrl_we && !ctrl_wdata[ABORT_BIT] && ctrl_wdata[14:0] != ctrl_q[14:0])
      |=> stat_q[BUSY_BIT]);

   // R3: rewriting the held command does nothing
   assert_same_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_q[BUSY_BIT] && ctrl_we && !ctrl_wdata[ABORT_BIT] && ctrl_wdata[14:0] == ctrl_q[14:0])
      |=> !stat_q[BUSY_BIT]);
endmodule

// File: tb/i2c_regbridge_tb.sv
module i2c_regbridge_tb;
   localparam int CLK_PERIOD = 10;
   localparam int QC         = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_we = 1'b0;
   logic [15:0] ctrl_wdata = '0;
   logic [15:0] ctrl_q, stat_q;
   logic        scl_oe, sda_oe;
   logic        scl_l, sda_l;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // bus target model state
   logic       slv_drv;
   logic       slv_clr = 1'b0;
   logic       mute = 1'b0;
   logic       p_scl, p_sda, addr_ok, sel, rd, ok_v;
   logic [7:0] shf, txb;
   logic [4:0] ptr;
   logic [7:0] sregs [20];
   int         sph, bitcnt, bidx, txc;

   // bus monitor state
   logic mon_clr = 1'b0;
   logic m_scl;
   int   falls, hi_w, min_hi;

   assign scl_l = !scl_oe;
   assign sda_l = !(sda_oe || slv_drv);

   i2c_regbridge #(.QUARTER_CYC(QC), .BASE_ID(6'd4), .NUM_REGS(20)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_we    (ctrl_we),
      .ctrl_wdata (ctrl_wdata),
      .ctrl_q     (ctrl_q),
      .stat_q     (stat_q),
      .scl_oe     (scl_oe),
      .sda_oe     (sda_oe),
      .sda_i      (sda_l)
   );

   // Target: pointer register at select 0, data register at select 1
   always @(negedge clk) begin
      if (!rst_n || slv_clr) begin
         if (!rst_n) for (int i = 0; i < 20; i++) sregs[i] <= 8'hC0 + 8'(i);
         slv_drv <= 1'b0; sph <= 0; bitcnt <= 0; bidx <= 0; txc <= 0;
         p_scl <= 1'b1; p_sda <= 1'b1;
         if (!rst_n) begin ptr <= '0; addr_ok <= 1'b0; sel <= 1'b0; rd <= 1'b0; shf <= '0; txb <= '0; end
      end else begin
         p_scl <= scl_l;
         p_sda <= sda_l;
         if (p_scl && scl_l && p_sda && !sda_l) begin
            sph <= 0; bitcnt <= 0; bidx <= 0; slv_drv <= 1'b0;
         end else if (p_scl && scl_l && !p_sda && sda_l) begin
            sph <= 0; bitcnt <= 0; bidx <= 0; slv_drv <= 1'b0;
         end else if (!p_scl && scl_l) begin
            if (sph == 0 && bitcnt < 8) begin
               shf <= {shf[6:0], sda_l};
               bitcnt <= bitcnt + 1;
            end
         end else if (p_scl && !scl_l) begin
            if (sph == 0 && bitcnt == 8) begin
               if (bidx == 0) begin
                  ok_v = (shf[7:2] == 6'd4) && !mute;
                  addr_ok <= ok_v; sel <= shf[1]; rd <= shf[0];
                  slv_drv <= ok_v;
               end else begin
                  if (addr_ok) begin
                     if (!sel) ptr <= shf[4:0];
                     else if (ptr < 20) sregs[ptr] <= shf;
                  end
                  slv_drv <= addr_ok;
               end
               sph <= 1;
            end else if (sph == 1) begin
               bitcnt <= 0;
               bidx <= bidx + 1;
               if (bidx == 0 && addr_ok && rd) begin
                  txb <= sregs[ptr];
                  slv_drv <= !sregs[ptr][7];
                  txc <= 1;
                  sph <= 2;
               end else begin
                  slv_drv <= 1'b0;
                  sph <= 0;
               end
            end else if (sph == 2) begin
               if (txc < 8) begin
                  slv_drv <= !txb[7-txc];
                  txc <= txc + 1;
               end else begin
                  slv_drv <= 1'b0;
                  sph <= 3;
               end
            end
         end
      end
   end

   always @(negedge clk) begin
      m_scl <= scl_l;
      if (mon_clr) begin
         falls <= 0; hi_w <= 0; min_hi <= 1000000;
      end else begin
         if (scl_l) hi_w <= hi_w + 1;
         if (m_scl && !scl_l) begin
            falls <= falls + 1;
            if (hi_w < min_hi) min_hi <= hi_w;
            hi_w <= 0;
         end
      end
   end

   task automatic check_eq(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic host_write(input logic [15:0] v);
      @(negedge clk);
      ctrl_we = 1'b1;
      ctrl_wdata = v;
      @(negedge clk);
      ctrl_we = 1'b0;
   endtask

   task automatic mon_reset();
      @(posedge clk); mon_clr = 1'b1;
      @(posedge clk); mon_clr = 1'b0;
   endtask

   task automatic wait_idle(input string req);
      int n = 0;
      @(negedge clk);
      while (stat_q[13] && n < 5000) begin
         @(negedge clk);
         n++;
      end
      check_eq(req, "busy timeout", int'(stat_q[13]), 0);
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check_eq("R1", "ctrl_q", int'(ctrl_q), 0);
      check_eq("R1", "stat_q", int'(stat_q), 0);
      check_eq("R1", "scl_oe", int'(scl_oe), 0);
      check_eq("R1", "sda_oe", int'(sda_oe), 0);
   endtask

   task automatic t_write();
      mon_reset();
      host_write(16'h23A5);
      check_eq("R2", "busy after start", int'(stat_q[13]), 1);
      check_eq("R2", "ctrl readback", int'(ctrl_q), 16'h23A5);
      wait_idle("R5");
      check_eq("R5", "target reg3", int'(sregs[3]), 8'hA5);
      check_eq("R5", "error", int'(stat_q[14]), 0);
      check_eq("R11", "scl falls", falls, 38);
      check_eq("R11", "min scl high", min_hi, 2*QC);
   endtask

   task automatic t_read(input logic [15:0] v, input int exp);
      mon_reset();
      host_write(v);
      wait_idle("R6");
      check_eq("R6", "read byte", int'(stat_q[7:0]), exp);
      check_eq("R6", "error", int'(stat_q[14]), 0);
      check_eq("R11", "scl falls read", falls, 38);
   endtask

   task automatic t_same();
      mon_reset();
      host_write(16'h1300);
      check_eq("R3", "busy", int'(stat_q[13]), 0);
      repeat (50) @(negedge clk);
      check_eq("R3", "scl falls", falls, 0);
   endtask

   task automatic t_busy_ignore();
      host_write(16'h2211);
      repeat (30) @(negedge clk);
      host_write(16'h2233);
      check_eq("R4", "ctrl kept", int'(ctrl_q), 16'h2211);
      check_eq("R4", "still busy", int'(stat_q[13]), 1);
      wait_idle("R4");
      check_eq("R4", "target reg2", int'(sregs[2]), 8'h11);
   endtask

   task automatic t_range();
      mon_reset();
      host_write(16'h1400);
      repeat (2) @(negedge clk);
      check_eq("R10", "busy", int'(stat_q[13]), 0);
      check_eq("R10", "error", int'(stat_q[14]), 1);
      check_eq("R10", "scl falls", falls, 0);
   endtask

   task automatic t_nack();
      @(posedge clk); mute = 1'b1;
      mon_reset();
      host_write(16'h2477);
      wait_idle("R7");
      check_eq("R7", "error", int'(stat_q[14]), 1);
      check_eq("R7", "scl falls", falls, 10);
      check_eq("R7", "target reg4", int'(sregs[4]), 8'hC4);
      check_eq("R7", "lines released", int'({scl_oe, sda_oe}), 0);
      @(posedge clk); mute = 1'b0;
      host_write(16'h2478);
      check_eq("R8", "error cleared", int'(stat_q[14]), 0);
      check_eq("R8", "busy", int'(stat_q[13]), 1);
      wait_idle("R8");
      check_eq("R8", "target reg4", int'(sregs[4]), 8'h78);
      check_eq("R8", "error after ok", int'(stat_q[14]), 0);
   endtask

   task automatic t_abort();
      host_write(16'h2155);
      repeat (100) @(negedge clk);
      host_write(16'h8000);
      check_eq("R9", "busy", int'(stat_q[13]), 0);
      check_eq("R9", "error", int'(stat_q[14]), 0);
      check_eq("R9", "lines released", int'({scl_oe, sda_oe}), 0);
      check_eq("R9", "ctrl cleared", int'(ctrl_q), 0);
      @(posedge clk); slv_clr = 1'b1;
      @(posedge clk); slv_clr = 1'b0;
      mon_reset();
      repeat (60) @(negedge clk);
      check_eq("R9", "no scl edges", falls, 0);
      check_eq("R9", "target reg1", int'(sregs[1]), 8'hC1);
      t_read(16'h0700, 8'hC7);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_write();
      t_read(16'h0700, 8'hC7);
      t_read(16'h1300, 8'hD3);
      t_same();
      t_busy_ignore();
      t_range();
      t_nack();
      t_abort();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule